// File: doc/BRIEF.md
# Banked GPIO Line Controller

This block implements one bank of general-purpose I/O lines behind a small word-addressed register port. Every line keeps its own configuration: alternate-function select, direction, pull resistor enables, input glitch filter controls, open-drain drive, Schmitt input and an event-type code. All lines share a single configuration window. A separately written line-select mask decides which lines that window touches.

Software first writes the mask and then reads or writes the configuration window. A write reaches every selected line in the same cycle, so a group of lines can be configured in one access. A read returns the settings of the lowest-numbered selected line. Output levels change through write-one-to-set and write-one-to-clear registers. Pin levels are read from a status register after a two-stage synchronizer. The pad electronics appear only as per-line control outputs and a digital input vector.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset, the mask, every line's configuration and the output latch are zero. All pad control outputs are zero, so every line is a plain GPIO input that drives low, with every enable cleared.
- R2: The mask register at byte offset 0x00 holds one select bit per line and reads back the value last written.
- R3: A write to the configuration window at offset 0x04 stores the word into every line whose mask bit is 1 and leaves every other line unchanged. The fields are: function select in bits 2:0, direction in bit 8 (1 = output), pull-up in bit 9, pull-down in bit 10, filter enable in bit 12, slow-clock filter in bit 13, open-drain in bit 14, Schmitt enable in bit 15, and event select in bits 26:24. All other bits are discarded and read as zero.
- R4: A read of offset 0x04 returns the configuration of the lowest-numbered line whose mask bit is 1, or zero when the mask is empty.
- R5: The per-line pad outputs follow the stored fields. Function select and event select each use a 3-bit slice per line, at bits 3*i+2:3*i, and direction drives the output-enable bit.
- R6: When a line has both pull-up and pull-down set, its pull-down pad output stays low and its pull-up pad output is high. The stored word still reads back with both bits set.
- R7: A write to offset 0x10 sets the output latch of every line whose data bit is 1. Zero bits leave their lines unchanged.
- R8: A write to offset 0x14 clears the output latch of every line whose data bit is 1. Zero bits leave their lines unchanged.
- R9: Offset 0x18 and the pad output vector return the output latch whatever each line's direction is.
- R10: Offset 0x08 returns the pad inputs through a two-flop synchronizer. A level applied just after a clock edge is not visible after the next edge, and is visible after the edge that follows it.
- R11: The lock status at 0x0C reads zero. Every other offset inside the 64-byte bank window, including misaligned ones, reads zero and ignores writes.
- R12: Writes to the read-only offsets 0x08, 0x0C and 0x18 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe; read data is zero while it is low |
| bus_addr | input | 6 | Byte offset within the bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as bus_rd |
| pad_in | input | NLINES | Raw pad input levels |
| pad_out | output | NLINES | Output latch per line |
| pad_oe | output | NLINES | Output enable (direction) per line |
| pad_func | output | 3*NLINES | Function select per line |
| pad_pull_up | output | NLINES | Pull-up enable per line |
| pad_pull_dn | output | NLINES | Pull-down enable per line, masked by pull-up |
| pad_filt_en | output | NLINES | Input filter enable per line |
| pad_filt_slow | output | NLINES | Slow-clock filter select per line |
| pad_open_drain | output | NLINES | Open-drain enable per line |
| pad_schmitt | output | NLINES | Schmitt input enable per line |
| pad_evt_sel | output | 3*NLINES | Event select per line |

## Verification
The bench builds the block with the default NLINES of 32. At that size the mask fills the whole bus word, so lines 0 and 31 are reachable: the bench can check a mask whose only bits are the top line and a middle line, and confirm that the lowest-line rule picks the middle one. Multi-line writes to adjacent lines, a pull-up and pull-down conflict on one line, and the exact synchronizer latency on a wide input pattern are all driven at this width.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int unsigned WORD_W  = 32;
  localparam int unsigned BANK_AW = 6;

  localparam logic [BANK_AW-1:0] OFS_MASK = 6'h00;
  localparam logic [BANK_AW-1:0] OFS_CFG  = 6'h04;
  localparam logic [BANK_AW-1:0] OFS_PIN  = 6'h08;
  localparam logic [BANK_AW-1:0] OFS_LOCK = 6'h0C;
  localparam logic [BANK_AW-1:0] OFS_SET  = 6'h10;
  localparam logic [BANK_AW-1:0] OFS_CLR  = 6'h14;
  localparam logic [BANK_AW-1:0] OFS_OUT  = 6'h18;

  localparam int unsigned B_FUNC = 0;
  localparam int unsigned B_DIR  = 8;
  localparam int unsigned B_PU   = 9;
  localparam int unsigned B_PD   = 10;
  localparam int unsigned B_FEN  = 12;
  localparam int unsigned B_FSLW = 13;
  localparam int unsigned B_OD   = 14;
  localparam int unsigned B_SCH  = 15;
  localparam int unsigned B_EVT  = 24;

  typedef struct packed {
    logic [2:0] evt;
    logic       schmitt;
    logic       od;
    logic       filt_slow;
    logic       filt_en;
    logic       pd;
    logic       pu;
    logic       dir;
    logic [2:0] func;
  } line_cfg_t;

  function automatic logic [WORD_W-1:0] cfg_to_word(input line_cfg_t c);
    logic [WORD_W-1:0] w;
    w = '0;
    w[B_FUNC +: 3] = c.func;
    w[B_DIR]       = c.dir;
    w[B_PU]        = c.pu;
    w[B_PD]        = c.pd;
    w[B_FEN]       = c.filt_en;
    w[B_FSLW]      = c.filt_slow;
    w[B_OD]        = c.od;
    w[B_SCH]       = c.schmitt;
    w[B_EVT +: 3]  = c.evt;
    return w;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned NLINES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] din,
  output logic [NLINES-1:0] dout
);

  logic [NLINES-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= din;
      s2_q <= s1_q;
    end
  end

  assign dout = s2_q;

  // cycles since reset, saturating at 2, so the past window stays inside them
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  p_two_stage_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd2) |-> (dout == $past(din, 2)));

endmodule

// File: rtl/gpio_line_cfg.sv
module gpio_line_cfg
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NLINES = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [NLINES-1:0]      sel,
  input  line_cfg_t              wcfg,
  output line_cfg_t [NLINES-1:0] cfg_o,
  output line_cfg_t              rd_cfg
);

  line_cfg_t [NLINES-1:0] cfg_q;
  line_cfg_t [NLINES-1:0] cfg_d;
  logic      [NLINES-1:0] line_en;

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    assign line_en[i] = wr_en & sel[i];

    always_comb begin
      cfg_d[i] = cfg_q[i];
      if (line_en[i]) cfg_d[i] = wcfg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cfg_q[i] <= '0;
      else if (line_en[i]) cfg_q[i] <= cfg_d[i];
    end

    p_cfg_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel[i]) |=> (cfg_q[i] == $past(wcfg)));
    p_cfg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && sel[i]) |=> $stable(cfg_q[i]));
  end

  // scan from the top so the lowest selected line wins
  always_comb begin
    rd_cfg = '0;
    for (int k = NLINES - 1; k >= 0; k--) begin
      if (sel[k]) rd_cfg = cfg_q[k];
    end
  end

  assign cfg_o = cfg_q;

endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch #(
  parameter int unsigned NLINES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic [NLINES-1:0] bits,
  output logic [NLINES-1:0] out_q
);

  logic [NLINES-1:0] out_d;
  logic              upd;

  assign upd = set_we | clr_we;

  always_comb begin
    out_d = out_q;
    if (set_we) out_d = out_d | bits;
    if (clr_we) out_d = out_d & ~bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   out_q <= '0;
    else if (upd) out_q <= out_d;
  end

  p_set_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we && !clr_we) |=> ((out_q & $past(bits)) == $past(bits)));
  p_set_zeros_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we && !clr_we) |=> ((out_q & ~$past(bits)) == ($past(out_q) & ~$past(bits))));
  p_clr_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !set_we) |=> ((out_q & $past(bits)) == '0));
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_we || clr_we) |=> $stable(out_q));

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NLINES = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [5:0]          bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NLINES-1:0]   pad_in,
  output logic [NLINES-1:0]   pad_out,
  output logic [NLINES-1:0]   pad_oe,
  output logic [3*NLINES-1:0] pad_func,
  output logic [NLINES-1:0]   pad_pull_up,
  output logic [NLINES-1:0]   pad_pull_dn,
  output logic [NLINES-1:0]   pad_filt_en,
  output logic [NLINES-1:0]   pad_filt_slow,
  output logic [NLINES-1:0]   pad_open_drain,
  output logic [NLINES-1:0]   pad_schmitt,
  output logic [3*NLINES-1:0] pad_evt_sel
);

  localparam int unsigned LW = NLINES;

  // ---- reset: asserted asynchronously, released on the clock ----
  logic [1:0] rst_pipe_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_i_n = rst_pipe_q[1];

  // ---- write decode ----
  logic wr_mask, wr_cfg, wr_set, wr_clr, wr_mapped;

  assign wr_mask   = bus_wr && (bus_addr == OFS_MASK);
  assign wr_cfg    = bus_wr && (bus_addr == OFS_CFG);
  assign wr_set    = bus_wr && (bus_addr == OFS_SET);
  assign wr_clr    = bus_wr && (bus_addr == OFS_CLR);
  assign wr_mapped = wr_mask | wr_cfg | wr_set | wr_clr;

  // ---- line-select mask ----
  logic [LW-1:0] mask_q, mask_d;

  always_comb begin
    mask_d = mask_q;
    if (wr_mask) mask_d = bus_wdata[LW-1:0];
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)     mask_q <= '0;
    else if (wr_mask) mask_q <= mask_d;
  end

  // ---- configuration word unpack (reserved bits dropped) ----
  line_cfg_t wcfg;
  always_comb begin
    wcfg.func      = bus_wdata[B_FUNC +: 3];
    wcfg.dir       = bus_wdata[B_DIR];
    wcfg.pu        = bus_wdata[B_PU];
    wcfg.pd        = bus_wdata[B_PD];
    wcfg.filt_en   = bus_wdata[B_FEN];
    wcfg.filt_slow = bus_wdata[B_FSLW];
    wcfg.od        = bus_wdata[B_OD];
    wcfg.schmitt   = bus_wdata[B_SCH];
    wcfg.evt       = bus_wdata[B_EVT +: 3];
  end

  line_cfg_t [LW-1:0] cfg;
  line_cfg_t          rd_cfg;

  gpio_line_cfg #(.NLINES(LW)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .wr_en  (wr_cfg),
    .sel    (mask_q),
    .wcfg   (wcfg),
    .cfg_o  (cfg),
    .rd_cfg (rd_cfg)
  );

  // ---- output latch ----
  logic [LW-1:0] out_q;

  gpio_out_latch #(.NLINES(LW)) u_out (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .set_we (wr_set),
    .clr_we (wr_clr),
    .bits   (bus_wdata[LW-1:0]),
    .out_q  (out_q)
  );

  // ---- input synchronizer ----
  logic [LW-1:0] pin_sync;

  gpio_in_sync #(.NLINES(LW)) u_sync (
    .clk   (clk),
    .rst_n (rst_i_n),
    .din   (pad_in),
    .dout  (pin_sync)
  );

  // ---- pad control fan-out ----
  for (genvar i = 0; i < LW; i++) begin : g_pad
    assign pad_func[3*i +: 3]    = cfg[i].func;
    assign pad_evt_sel[3*i +: 3] = cfg[i].evt;
    assign pad_oe[i]             = cfg[i].dir;
    assign pad_pull_up[i]        = cfg[i].pu;
    assign pad_pull_dn[i]        = cfg[i].pd & ~cfg[i].pu;
    assign pad_filt_en[i]        = cfg[i].filt_en;
    assign pad_filt_slow[i]      = cfg[i].filt_slow;
    assign pad_open_drain[i]     = cfg[i].od;
    assign pad_schmitt[i]        = cfg[i].schmitt;
  end

  assign pad_out = out_q;

  // ---- read mux ----
  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        OFS_MASK: bus_rdata[LW-1:0] = mask_q;
        OFS_CFG:  bus_rdata         = cfg_to_word(rd_cfg);
        OFS_PIN:  bus_rdata[LW-1:0] = pin_sync;
        OFS_OUT:  bus_rdata[LW-1:0] = out_q;
        default:  bus_rdata         = '0;
      endcase
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^{bus_wdata[31:27], bus_wdata[23:16], bus_wdata[11], bus_wdata[7:3]};

  p_mask_load_r2: assert property (@(posedge clk) disable iff (!rst_i_n)
    wr_mask |=> (mask_q == $past(bus_wdata[LW-1:0])));
  p_unmapped_wr_r11: assert property (@(posedge clk) disable iff (!rst_i_n)
    (bus_wr && !wr_mapped) |=> ($stable(mask_q) && $stable(out_q) && $stable(cfg)));
  p_pull_yield_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (wr_cfg && bus_wdata[B_PU] && (mask_q != '0)) |=> ((pad_pull_dn & $past(mask_q)) == '0));

endmodule

// File: tb/gpio_bank_regs_test.sv
module gpio_bank_regs_test;

  localparam int  N      = 32;
  localparam time CLK_PD = 10ns;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_wr = 1'b0;
  logic            bus_rd = 1'b0;
  logic [5:0]      bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [N-1:0]    pad_in = '0;
  logic [N-1:0]    pad_out, pad_oe, pad_pull_up, pad_pull_dn;
  logic [N-1:0]    pad_filt_en, pad_filt_slow, pad_open_drain, pad_schmitt;
  logic [3*N-1:0]  pad_func, pad_evt_sel;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [31:0] q_exp[$];
  string       q_tag[$];
  logic [31:0] mon_e;
  string       mon_t;

  always #(CLK_PD/2) clk = ~clk;

  gpio_bank_regs #(.NLINES(N)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_func(pad_func),
    .pad_pull_up(pad_pull_up), .pad_pull_dn(pad_pull_dn),
    .pad_filt_en(pad_filt_en), .pad_filt_slow(pad_filt_slow),
    .pad_open_drain(pad_open_drain), .pad_schmitt(pad_schmitt),
    .pad_evt_sel(pad_evt_sel)
  );

  // monitor: pops one expected word per read cycle, mid-cycle
  always @(negedge clk) begin
    if (rst_n && bus_rd) begin
      checks++;
      if (q_exp.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: read with no expectation, rdata %h expected none", bus_rdata);
      end else begin
        mon_e = q_exp.pop_front();
        mon_t = q_tag.pop_front();
        if (bus_rdata !== mon_e) begin
          errors++;
          $display("FAIL %s: rdata %h expected %h", mon_t, bus_rdata, mon_e);
        end
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_rd = 1'b0; bus_addr = a; bus_wdata = d;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] e, input string tag);
    @(posedge clk); #1;
    q_exp.push_back(e);
    q_tag.push_back(tag);
    bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = a; bus_wdata = '0;
  endtask

  task automatic idle();
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic chk(input logic [95:0] act, input logic [95:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;

    // R1 reset state
    chk(pad_out, '0, "R1 pad_out");
    chk(pad_oe | pad_pull_up | pad_pull_dn | pad_schmitt | pad_open_drain | pad_filt_en | pad_filt_slow, '0, "R1 enables");
    chk(pad_func | pad_evt_sel, '0, "R1 func/evt");
    rd(6'h00, 32'h0, "R1 mask");
    rd(6'h04, 32'h0, "R1 cfg");
    rd(6'h18, 32'h0, "R1 out status");
    rd(6'h08, 32'h0, "R1 pin status");

    // R2 mask register
    wr(6'h00, 32'hA5A5_0F0F);
    rd(6'h00, 32'hA5A5_0F0F, "R2 mask readback");

    // R3 group write to lines 1 and 2, reserved bits dropped
    wr(6'h00, 32'h0000_0006);
    wr(6'h04, 32'hFFFF_FFFF);
    wr(6'h00, 32'h0000_0002);
    rd(6'h04, 32'h0700_F707, "R3 line1 fields");
    wr(6'h00, 32'h0000_0004);
    rd(6'h04, 32'h0700_F707, "R3 line2 fields");
    wr(6'h00, 32'h0000_0001);
    rd(6'h04, 32'h0, "R3 line0 untouched");
    wr(6'h00, 32'h0000_0008);
    rd(6'h04, 32'h0, "R3 line3 untouched");

    // R4 lowest selected line wins; empty mask reads zero
    wr(6'h00, 32'h8000_0000);
    wr(6'h04, 32'h0100_8103);
    rd(6'h04, 32'h0100_8103, "R4 line31 alone");
    wr(6'h00, 32'h8000_0020);
    rd(6'h04, 32'h0, "R4 line5 below line31");
    wr(6'h00, 32'h8000_0004);
    rd(6'h04, 32'h0700_F707, "R4 line2 below line31");
    wr(6'h00, 32'h0);
    rd(6'h04, 32'h0, "R4 empty mask");

    // R6 pull-down only on line 4
    wr(6'h00, 32'h0000_0010);
    wr(6'h04, 32'h0000_0400);
    idle();
    // R5 pad fan-out
    chk(pad_oe, 32'h8000_0006, "R5 pad_oe");
    chk(pad_func[3*1 +: 3], 3'd7, "R5 func line1");
    chk(pad_func[3*31 +: 3], 3'd3, "R5 func line31");
    chk(pad_evt_sel[3*31 +: 3], 3'd1, "R5 evt line31");
    chk(pad_evt_sel[3*2 +: 3], 3'd7, "R5 evt line2");
    chk(pad_schmitt, 32'h8000_0006, "R5 schmitt");
    chk(pad_open_drain | pad_filt_en | pad_filt_slow, {3{32'h0000_0006}} & 32'h0000_0006, "R5 od/filter");
    // R6 pull-up wins over pull-down at the pad
    chk(pad_pull_up, 32'h0000_0006, "R6 pull_up");
    chk(pad_pull_dn, 32'h0000_0010, "R6 pull_dn");
    wr(6'h00, 32'h0000_0002);
    rd(6'h04, 32'h0700_F707, "R6 stored pd bit kept");

    // R7 set register
    wr(6'h10, 32'h0000_00F0);
    rd(6'h18, 32'h0000_00F0, "R7 set F0");
    wr(6'h10, 32'h0000_0003);
    rd(6'h18, 32'h0000_00F3, "R7 zero bits no effect");
    // R8 clear register
    wr(6'h14, 32'h0000_0011);
    rd(6'h18, 32'h0000_00E2, "R8 clear 11");
    idle();
    // R9 latch visible on inputs too (lines 5..7 are inputs)
    chk(pad_out, 32'h0000_00E2, "R9 pad_out");

    // R10 synchronizer latency
    pad_in = 32'h1234_5678;
    rd(6'h08, 32'h0, "R10 not yet after one edge");
    rd(6'h08, 32'h1234_5678, "R10 visible after two edges");
    pad_in = 32'hFFFF_0000;
    rd(6'h08, 32'h1234_5678, "R10 old value one edge");
    rd(6'h08, 32'hFFFF_0000, "R10 new value two edges");

    // R11 lock and unmapped
    rd(6'h0C, 32'h0, "R11 lock zero");
    rd(6'h1C, 32'h0, "R11 unmapped 1C");
    rd(6'h3C, 32'h0, "R11 unmapped 3C");
    rd(6'h02, 32'h0, "R11 misaligned");
    wr(6'h00, 32'h0000_0002);
    wr(6'h1C, 32'hFFFF_FFFF);
    wr(6'h01, 32'hFFFF_FFFF);
    wr(6'h11, 32'hFFFF_FFFF);
    rd(6'h00, 32'h0000_0002, "R11 mask kept");
    rd(6'h18, 32'h0000_00E2, "R11 latch kept");
    rd(6'h04, 32'h0700_F707, "R11 cfg kept");

    // R12 read-only offsets
    wr(6'h18, 32'hFFFF_FFFF);
    wr(6'h08, 32'h0000_0000);
    wr(6'h0C, 32'hFFFF_FFFF);
    rd(6'h18, 32'h0000_00E2, "R12 out status kept");
    rd(6'h00, 32'h0000_0002, "R12 mask kept");
    idle();
    chk(pad_oe, 32'h8000_0006, "R12 pad_oe kept");

    @(negedge clk);
    if (q_exp.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL scoreboard: %0d reads never seen, expected 0", q_exp.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule